// File: doc/BRIEF.md
# Dual-Domain Two-Key Register Unlock Controller

This block protects two groups of memory-controller control registers, a main control group and an option group, behind their own lock bits. Each group (a domain) stays locked until software writes two fixed 32-bit keys, in the right order, to that domain's key register. Each domain has its own key pair and its own sequence state, so activity in one domain never disturbs the other.

Unlocking is single-shot. A wrong key, a wrong order, a key write that is not word-sized, or any key write while the domain is already open counts as a failed attempt. A failed attempt locks the domain until the next reset, and from then on every key write to that domain is ignored. While a domain is unlocked, software relocks it by writing its control register with the lock bit set. Writes to a locked control register are dropped, and a one-cycle marker reports each dropped write.

All outputs are registered. Each takes its new value in the cycle after the write strobe that causes it.

Top module: `key_unlock_ctrl`

## Requirements
- R1: After reset both `main_locked` and `opt_locked` are 1, and both lockout outputs and both ignored-write markers are 0.
- R2: Writing word 0x45670123 to word address 0 (main key) and then word 0xCDEF89AB as the next write to address 0 clears `main_locked` in the cycle after the second write.
- R3: Writing word 0x08192A3B to word address 2 (option key) and then word 0x4C5D6E7F as the next write to address 2 clears `opt_locked` in the cycle after the second write.
- R4: A first key write with a wrong value sets the domain's lockout. Lockout and lock both stay 1 until reset, and a later correct key sequence has no effect.
- R5: A wrong second key, or the second key written with no first key before it, sets the domain's lockout and keeps it locked.
- R6: Any key write to a domain that is unlocked sets that domain's lock and lockout.
- R7: A key write whose `wr_size` is not 2'b10 (word; 2'b00 byte, 2'b01 half-word) counts as a failed attempt, even when the data matches the expected key.
- R8: A write to an unlocked domain's control register (word address 1 main, 3 option) with data bit 0 set relocks the domain and restarts its key sequence. The same write with bit 0 clear has no effect.
- R9: A write to a locked domain's control register is ignored. The domain's `*_wr_ignored` output is 1 for exactly the one cycle after that write and is 0 at all other times.
- R10: The two domains keep separate sequence state. Key or control writes to one domain do not change the lock, lockout or pending first key of the other.
- R11: Writes to word addresses 4 and above change no output.
- R12: Reset clears a lockout and returns both domains to locked with no key pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| wr_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| main_locked | output | 1 | Main control group locked |
| opt_locked | output | 1 | Option group locked |
| main_lockout | output | 1 | Main domain permanently locked until reset |
| opt_lockout | output | 1 | Option domain permanently locked until reset |
| main_wr_ignored | output | 1 | Main control write dropped (one-cycle pulse) |
| opt_wr_ignored | output | 1 | Option control write dropped (one-cycle pulse) |

## Verification
Every output is registered straight from the domain state. A wrong internal state therefore reaches the ports one cycle after the write that causes it. A pending first key lost or kept by mistake only shows one key write later, as an unlock that happens when it should not, or a lockout where an unlock was due. The bench steps a behavioural model on every clock and compares all six outputs each cycle. This catches a wrong transition in the very cycle it becomes visible. The stimulus deliberately separates the two keys of a domain with writes to the other domain and to unmapped addresses, so that a disturbed pending key is exposed.

// File: rtl/kuc_pkg.sv
package kuc_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned N_DOM   = 2;
    localparam logic [1:0]  SZ_WORD = 2'b10;

    // Per-domain sequence state. LOCKED..HALF are locked, DEAD is a lockout.
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2,
        ST_DEAD   = 2'd3
    } dom_state_e;

    typedef struct packed {
        dom_state_e st;
        logic       ign;
    } dom_reg_t;

    // Domain 0 is the main control group, domain 1 the option group.
    function automatic logic [DATA_W-1:0] first_key(input int d);
        return (d == 0) ? 32'h4567_0123 : 32'h0819_2A3B;
    endfunction

    function automatic logic [DATA_W-1:0] second_key(input int d);
        return (d == 0) ? 32'hCDEF_89AB : 32'h4C5D_6E7F;
    endfunction

endpackage

// File: rtl/kuc_decode.sv
module kuc_decode
    import kuc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    output logic [N_DOM-1:0]  key_wr,
    output logic [N_DOM-1:0]  ctl_wr,
    output logic              word_sz
);

    // Each domain owns two consecutive words: key, then control.
    for (genvar g = 0; g < N_DOM; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(2 * g + 1);
        assign key_wr[g] = wr_en && (wr_addr == KEY_A);
        assign ctl_wr[g] = wr_en && (wr_addr == CTL_A);
    end

    assign word_sz = (wr_size == SZ_WORD);

endmodule

// File: rtl/kuc_domain.sv
module kuc_domain
    import kuc_pkg::*;
#(
    parameter logic [DATA_W-1:0] FIRST_KEY  = 32'h0,
    parameter logic [DATA_W-1:0] SECOND_KEY = 32'h0,
    parameter int unsigned       LOCK_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              ctl_wr,
    input  logic              word_sz,
    input  logic [DATA_W-1:0] wr_data,
    output logic              locked,
    output logic              lockout,
    output logic              wr_ignored
);

    dom_reg_t r_d, r_q;
    logic     key1_ok, key2_ok;

    assign key1_ok = word_sz && (wr_data == FIRST_KEY);
    assign key2_ok = word_sz && (wr_data == SECOND_KEY);

    always_comb begin
        r_d     = r_q;
        r_d.ign = 1'b0;
        unique case (r_q.st)
            ST_LOCKED: begin
                if (key_wr) r_d.st = key1_ok ? ST_HALF : ST_DEAD;
            end
            ST_HALF: begin
                if (key_wr) r_d.st = key2_ok ? ST_OPEN : ST_DEAD;
            end
            ST_OPEN: begin
                if (key_wr)
                    r_d.st = ST_DEAD;
                else if (ctl_wr && wr_data[LOCK_BIT])
                    r_d.st = ST_LOCKED;
            end
            default: r_d.st = ST_DEAD;
        endcase
        if (ctl_wr && (r_q.st != ST_OPEN)) r_d.ign = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_LOCKED;
            r_q.ign <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign locked     = (r_q.st != ST_OPEN);
    assign lockout    = (r_q.st == ST_DEAD);
    assign wr_ignored = r_q.ign;

endmodule

// File: rtl/key_unlock_ctrl.sv
module key_unlock_ctrl
    import kuc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned LOCK_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        wr_size,
    output logic              main_locked,
    output logic              opt_locked,
    output logic              main_lockout,
    output logic              opt_lockout,
    output logic              main_wr_ignored,
    output logic              opt_wr_ignored
);

    logic [N_DOM-1:0] key_wr, ctl_wr;
    logic [N_DOM-1:0] lk, lko, ign;
    logic             word_sz;

    kuc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_size (wr_size),
        .key_wr  (key_wr),
        .ctl_wr  (ctl_wr),
        .word_sz (word_sz)
    );

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        kuc_domain #(
            .FIRST_KEY  (first_key(g)),
            .SECOND_KEY (second_key(g)),
            .LOCK_BIT   (LOCK_BIT)
        ) u_dom (
            .clk        (clk),
            .rst_n      (rst_n),
            .key_wr     (key_wr[g]),
            .ctl_wr     (ctl_wr[g]),
            .word_sz    (word_sz),
            .wr_data    (wr_data),
            .locked     (lk[g]),
            .lockout    (lko[g]),
            .wr_ignored (ign[g])
        );
    end

    assign main_locked     = lk[0];
    assign opt_locked      = lk[1];
    assign main_lockout    = lko[0];
    assign opt_lockout     = lko[1];
    assign main_wr_ignored = ign[0];
    assign opt_wr_ignored  = ign[1];

endmodule

// File: rtl/kuc_checker.sv
module kuc_checker #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned LOCK_BIT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [1:0]        wr_size,
    input logic              main_locked,
    input logic              opt_locked,
    input logic              main_lockout,
    input logic              opt_lockout,
    input logic              main_wr_ignored,
    input logic              opt_wr_ignored
);

    logic mk_wr, mc_wr, ok_wr, oc_wr;
    assign mk_wr = wr_en && (wr_addr == ADDR_W'(0));
    assign mc_wr = wr_en && (wr_addr == ADDR_W'(1));
    assign ok_wr = wr_en && (wr_addr == ADDR_W'(2));
    assign oc_wr = wr_en && (wr_addr == ADDR_W'(3));

    // R2: main unlock only right after a word write of the second main key
    a_r2_main_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_locked) |-> $past(mk_wr && wr_size == 2'b10 && wr_data == 32'hCDEF_89AB));
    // R3: option unlock only right after a word write of the second option key
    a_r3_opt_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(opt_locked) |-> $past(ok_wr && wr_size == 2'b10 && wr_data == 32'h4C5D_6E7F));
    // R4: lockout is sticky and implies locked
    a_r4_main_lockout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        main_lockout |=> main_lockout);
    a_r4_opt_lockout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        opt_lockout |=> opt_lockout);
    a_r4_main_lockout_locked: assert property (@(posedge clk) disable iff (!rst_n)
        main_lockout |-> main_locked);
    a_r4_opt_lockout_locked: assert property (@(posedge clk) disable iff (!rst_n)
        opt_lockout |-> opt_locked);
    // R8: relock needs a control write with the lock bit or a key write
    a_r8_main_relock_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_locked) |-> $past(mk_wr || (mc_wr && wr_data[LOCK_BIT])));
    a_r8_opt_relock_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(opt_locked) |-> $past(ok_wr || (oc_wr && wr_data[LOCK_BIT])));
    // R9: ignored marker follows a control write to a locked domain
    a_r9_main_ign_cause: assert property (@(posedge clk) disable iff (!rst_n)
        main_wr_ignored |-> $past(mc_wr && main_locked));
    a_r9_opt_ign_cause: assert property (@(posedge clk) disable iff (!rst_n)
        opt_wr_ignored |-> $past(oc_wr && opt_locked));
    // R10: a write to one domain never starts a lockout in the other
    a_r10_main_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_lockout) |-> $past(mk_wr));
    a_r10_opt_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(opt_lockout) |-> $past(ok_wr));

endmodule

bind key_unlock_ctrl kuc_checker #(.ADDR_W(ADDR_W), .LOCK_BIT(LOCK_BIT)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .wr_size         (wr_size),
    .main_locked     (main_locked),
    .opt_locked      (opt_locked),
    .main_lockout    (main_lockout),
    .opt_lockout     (opt_lockout),
    .main_wr_ignored (main_wr_ignored),
    .opt_wr_ignored  (opt_wr_ignored)
);

// File: tb/tb_key_unlock_ctrl.sv
module tb_key_unlock_ctrl;

    localparam int ADDR_W = 4;
    localparam logic [31:0] MK1 = 32'h4567_0123, MK2 = 32'hCDEF_89AB;
    localparam logic [31:0] OK1 = 32'h0819_2A3B, OK2 = 32'h4C5D_6E7F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [1:0]        wr_size = 2'b10;
    logic main_locked, opt_locked, main_lockout, opt_lockout;
    logic main_wr_ignored, opt_wr_ignored;

    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    key_unlock_ctrl #(.ADDR_W(ADDR_W), .LOCK_BIT(0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size(wr_size),
        .main_locked(main_locked), .opt_locked(opt_locked),
        .main_lockout(main_lockout), .opt_lockout(opt_lockout),
        .main_wr_ignored(main_wr_ignored), .opt_wr_ignored(opt_wr_ignored)
    );

    // Reference model: per domain 0 locked, 1 first key seen, 2 open, 3 dead.
    int m_st[2];
    bit m_ign[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin m_st[d] <= 0; m_ign[d] <= 0; end
        end else begin
            for (int d = 0; d < 2; d++) begin
                int  ka, ca;
                bit  kw, cw, good1, good2;
                ka = 2 * d; ca = 2 * d + 1;
                kw = wr_en && (int'(wr_addr) == ka);
                cw = wr_en && (int'(wr_addr) == ca);
                good1 = (wr_size == 2'b10) && (wr_data == (d == 0 ? MK1 : OK1));
                good2 = (wr_size == 2'b10) && (wr_data == (d == 0 ? MK2 : OK2));
                m_ign[d] <= cw && (m_st[d] != 2);
                if (kw) begin
                    if (m_st[d] == 0)      m_st[d] <= good1 ? 1 : 3;
                    else if (m_st[d] == 1) m_st[d] <= good2 ? 2 : 3;
                    else                   m_st[d] <= 3;
                end else if (cw && m_st[d] == 2 && wr_data[0]) begin
                    m_st[d] <= 0;
                end
            end
        end
    end

    task automatic cmp(string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", cur_req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("main_locked",  main_locked,  m_st[0] != 2);
            cmp("opt_locked",   opt_locked,   m_st[1] != 2);
            cmp("main_lockout", main_lockout, m_st[0] == 3);
            cmp("opt_lockout",  opt_lockout,  m_st[1] == 3);
            cmp("main_ign",     main_wr_ignored, m_ign[0]);
            cmp("opt_ign",      opt_wr_ignored,  m_ign[1]);
        end
    end

    task automatic wr(int a, logic [31:0] d, logic [1:0] sz = 2'b10);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; wr_size = sz;
        @(negedge clk);
        wr_en = 1'b0; wr_size = 2'b10;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        do_reset();
        idle(1);
        cur_req = "R1";
        cmp("reset main_locked", main_locked, 1'b1);
        cmp("reset opt_locked", opt_locked, 1'b1);
        cmp("reset main_lockout", main_lockout, 1'b0);
        cmp("reset opt_ign", opt_wr_ignored, 1'b0);

        cur_req = "R11";
        wr(7, MK1); wr(0, MK1); wr(9, MK2); wr(15, 32'hFFFF_FFFF);
        cmp("unmapped no lockout", main_lockout, 1'b0);
        cur_req = "R2";
        wr(0, MK2);
        cmp("main unlocked", main_locked, 1'b0);
        cmp("opt still locked", opt_locked, 1'b1);

        cur_req = "R8";
        wr(1, 32'hFFFF_FFFE);
        cmp("bit0 clear keeps open", main_locked, 1'b0);
        wr(1, 32'h0000_0001);
        cmp("bit0 set relocks", main_locked, 1'b1);
        wr(0, MK1); wr(0, MK2);
        cmp("unlock after relock", main_locked, 1'b0);
        cmp("no lockout after relock", main_lockout, 1'b0);

        cur_req = "R9";
        wr(3, 32'h0);
        cmp("opt ctrl ignored pulse", opt_wr_ignored, 1'b1);
        cmp("main no pulse", main_wr_ignored, 1'b0);
        idle(1);
        cmp("pulse one cycle", opt_wr_ignored, 1'b0);

        cur_req = "R3";
        wr(2, OK1); wr(2, OK2);
        cmp("opt unlocked", opt_locked, 1'b0);

        cur_req = "R6";
        wr(2, OK1);
        cmp("opt relocked", opt_locked, 1'b1);
        cmp("opt lockout", opt_lockout, 1'b1);
        cmp("main untouched", main_locked, 1'b0);

        cur_req = "R12";
        do_reset(); idle(1);
        cmp("lockout cleared", opt_lockout, 1'b0);
        cmp("locked after reset", main_locked, 1'b1);

        cur_req = "R10";
        wr(2, OK1); wr(0, MK1); wr(3, 32'h1); wr(1, 32'h0); wr(2, OK2);
        cmp("opt unlocked interleaved", opt_locked, 1'b0);
        cmp("main pending", main_locked, 1'b1);
        wr(0, MK2);
        cmp("main unlocked interleaved", main_locked, 1'b0);

        cur_req = "R4";
        do_reset();
        wr(0, 32'h1234_5678);
        cmp("wrong first lockout", main_lockout, 1'b1);
        wr(0, MK1); wr(0, MK2);
        cmp("still locked", main_locked, 1'b1);
        wr(1, 32'h1);
        cmp("ctrl ignored in lockout", main_wr_ignored, 1'b1);
        cmp("opt unaffected", opt_lockout, 1'b0);

        cur_req = "R5";
        do_reset();
        wr(0, MK2);
        cmp("second key alone", main_lockout, 1'b1);
        wr(2, OK1); wr(2, OK1);
        cmp("wrong second key", opt_lockout, 1'b1);
        cmp("opt locked", opt_locked, 1'b1);

        cur_req = "R7";
        do_reset();
        wr(0, MK1, 2'b00);
        cmp("byte key write fails", main_lockout, 1'b1);
        wr(2, OK1); wr(2, OK2, 2'b01);
        cmp("half key write fails", opt_lockout, 1'b1);

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule